// File: doc/BRIEF.md
# Saturating Vector Element ALU

This block walks a vector of up to `MAX_VL` elements, one element per clock, adding or subtracting matching elements of two packed source registers. Each source element is 8, 16, 32 or 64 bits wide, and the destination width is chosen separately. The sum or difference is formed exactly at the wider of the two widths. It is then either wrapped or clamped to the destination width. The clamp uses the signed range or the unsigned range, as selected.

When recording is on, a flag per element tells whether that element was clamped. The flag never merges into any accumulated summary bit. Asking for saturation together with the overflow-enable bit is an illegal combination. The block rejects it in one cycle and writes nothing.

A launch is a one-cycle `start` pulse while the unit is idle. The unit captures the configuration and both source registers at that edge. Element `i` occupies bits `[i*w +: w]` of its packed register, where `w` is the element width in bits. Destination elements at index `VL` and above keep their previous contents.

Top module: `vecSatAlu`

## Requirements
- R1: After reset `busy`, `done` and `illegal` are 0, `dstVec` is all zeros and `ovFlags` is all zeros.
- R2: A launch with VL = n > 0 writes element 0 at the next edge and the following elements in ascending index order, one per edge. `busy` is high while elements are being written. `done` is high for one cycle, n+1 edges after the launch edge, with `busy` low.
- R3: With `satEn` = 0 the result is the exact sum or difference taken modulo 2^w of the destination width, and every bit of `ovFlags` is 0.
- R4: With `satEn` = 1 and `isSigned` = 1, a result above 2^(w-1)-1 becomes 2^(w-1)-1 and a result below -2^(w-1) becomes -2^(w-1), where w is the destination width.
- R5: With `satEn` = 1 and `isSigned` = 0, the sources are zero-extended. A result above 2^w-1 becomes 2^w-1 and a negative result becomes 0.
- R6: With `recEn` = 1 and `satEn` = 1, `ovFlags[i]` is 1 exactly when element i was clamped. With `recEn` = 0, every flag is 0.
- R7: Every launch clears all of `ovFlags`. Each flag depends only on its own element, and no flag accumulates across elements or across operations.
- R8: A launch with `satEn` = 1 and `ovEn` = 1 raises `illegal` and `done` together for one cycle, one edge after the launch. It leaves `dstVec` unchanged and `ovFlags` all zero.
- R9: Width codes are 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Sources are sign-extended when `isSigned` = 1 and zero-extended otherwise. The arithmetic loses nothing at the wider of the two widths before the result is clamped or wrapped to the destination width.
- R10: A launch with VL = 0 raises `done` one edge later, without `busy` and without changing `dstVec`.
- R11: A `start` pulse while `busy` is high is ignored: the running operation keeps its captured configuration and operands.
- R12: Destination elements at index VL and above, and all bits above the last written element, keep their previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse; only acted on while idle |
| vl | input | $clog2(MAX_VL+1) | Vector length; values above MAX_VL are treated as MAX_VL |
| srcWidth | input | 2 | Source element width code |
| dstWidth | input | 2 | Destination element width code |
| isSigned | input | 1 | 1 selects signed extension and signed clamp |
| opSub | input | 1 | 1 selects A minus B, 0 selects A plus B |
| satEn | input | 1 | Saturation enable |
| recEn | input | 1 | Record per-element overflow flags |
| ovEn | input | 1 | Overflow-enable bit; illegal together with satEn |
| srcA | input | MAX_VL*64 | Packed first source register |
| srcB | input | MAX_VL*64 | Packed second source register |
| busy | output | 1 | An operation is writing elements |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-combination pulse |
| dstVec | output | MAX_VL*64 | Packed destination register |
| ovFlags | output | MAX_VL | Per-element saturation flags |

## Verification
Some behaviours are checked by assertions on every cycle. These cover the launch-to-`done` distance measured against the captured length, the one-edge response to an illegal combination or a zero length, the unchanged destination while `illegal` shows, and flags that stay zero whenever the running operation has saturation off. Other behaviours only show up in the bench's scenarios and its independent element model. These are the clamp values at each width pairing, the choice between sign and zero extension, the per-element independence of the flags, and the preservation of elements past VL. The same applies to a `start` pulse during a run: only the final result can show that it was ignored.

// File: rtl/vecSatAlu_pkg.sv
package vecSatAlu_pkg;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } elemWidth_t;

  typedef struct packed {
    logic load;
    logic wrEn;
  } ctrlStrobes_t;

endpackage

// File: rtl/vecSatAlu_ctrl.sv
module vecSatAlu_ctrl
  import vecSatAlu_pkg::*;
#(
  parameter int MAX_VL = 8,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int IDXW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  input  logic           satEn,
  input  logic           ovEn,
  output ctrlStrobes_t   strobes,
  output logic [IDXW-1:0] elemIdx,
  output logic           busy,
  output logic           done,
  output logic           illegal
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t      state;
  logic [IDXW-1:0] lastIdx;
  logic [VLW-1:0]  vlEff;
  logic            launch;
  logic            badCombo;

  always_comb begin
    vlEff    = (vl > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl;
    launch   = start && (state == ST_IDLE);
    badCombo = satEn && ovEn;
    strobes.load = launch;
    strobes.wrEn = (state == ST_RUN);
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      elemIdx <= '0;
      lastIdx <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            elemIdx <= '0;
            if (badCombo) begin
              illegal <= 1'b1;
              done    <= 1'b1;
            end else if (vlEff == '0) begin
              done <= 1'b1;
            end else begin
              lastIdx <= IDXW'(vlEff - 1'b1);
              state   <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (elemIdx == lastIdx) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            elemIdx <= elemIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vecSatAlu_dp.sv
module vecSatAlu_dp
  import vecSatAlu_pkg::*;
#(
  parameter int MAX_VL = 8,
  localparam int PACKW = MAX_VL * 64,
  localparam int IDXW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [IDXW-1:0]  elemIdx,
  input  logic [PACKW-1:0] srcA,
  input  logic [PACKW-1:0] srcB,
  input  logic [1:0]       srcWidth,
  input  logic [1:0]       dstWidth,
  input  logic             isSigned,
  input  logic             opSub,
  input  logic             satEn,
  input  logic             recEn,
  output logic [PACKW-1:0] dstVec,
  output logic [MAX_VL-1:0] ovFlags
);

  // Configuration and operands captured at launch
  logic [PACKW-1:0] opA, opB;
  elemWidth_t       srcQ, dstQ;
  logic             sgnQ, subQ, satQ, recQ;

  // Per-element arithmetic
  logic signed [65:0] wideA, wideB, exact;
  logic signed [65:0] hiLim, loLim;
  logic               aboveHi, belowLo, clampHit;
  logic [63:0]        resElem;

  function automatic logic [63:0] pickElem(input logic [PACKW-1:0] vec,
                                           input logic [IDXW-1:0] idx,
                                           input elemWidth_t w);
    logic [63:0] r;
    r = '0;
    case (w)
      EW8:  r[7:0]  = vec[idx*8 +: 8];
      EW16: r[15:0] = vec[idx*16 +: 16];
      EW32: r[31:0] = vec[idx*32 +: 32];
      default: r    = vec[idx*64 +: 64];
    endcase
    return r;
  endfunction

  function automatic logic signed [65:0] widen(input logic [63:0] raw,
                                               input elemWidth_t w,
                                               input logic sgn);
    logic [63:0] m;
    case (w)
      EW8:  m = {{56{sgn & raw[7]}},  raw[7:0]};
      EW16: m = {{48{sgn & raw[15]}}, raw[15:0]};
      EW32: m = {{32{sgn & raw[31]}}, raw[31:0]};
      default: m = raw;
    endcase
    return $signed({{2{sgn & m[63]}}, m});
  endfunction

  always_comb begin
    wideA = widen(pickElem(opA, elemIdx, srcQ), srcQ, sgnQ);
    wideB = widen(pickElem(opB, elemIdx, srcQ), srcQ, sgnQ);
    // 66 bits hold any sum or difference of two 64-bit operands exactly
    exact = subQ ? (wideA - wideB) : (wideA + wideB);

    case (dstQ)
      EW8: begin
        hiLim = sgnQ ? 66'sd127 : 66'sd255;
        loLim = sgnQ ? -66'sd128 : 66'sd0;
      end
      EW16: begin
        hiLim = sgnQ ? 66'sd32767 : 66'sd65535;
        loLim = sgnQ ? -66'sd32768 : 66'sd0;
      end
      EW32: begin
        hiLim = sgnQ ? 66'sd2147483647 : 66'sd4294967295;
        loLim = sgnQ ? -66'sd2147483648 : 66'sd0;
      end
      default: begin
        hiLim = sgnQ ? 66'sh0_7FFF_FFFF_FFFF_FFFF : 66'sh0_FFFF_FFFF_FFFF_FFFF;
        loLim = sgnQ ? -66'sh0_8000_0000_0000_0000 : 66'sd0;
      end
    endcase

    aboveHi  = exact > hiLim;
    belowLo  = exact < loLim;
    clampHit = satQ && (aboveHi || belowLo);

    if (satQ && aboveHi)      resElem = hiLim[63:0];
    else if (satQ && belowLo) resElem = loLim[63:0];
    else                      resElem = exact[63:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA  <= '0;
      opB  <= '0;
      srcQ <= EW8;
      dstQ <= EW8;
      sgnQ <= 1'b0;
      subQ <= 1'b0;
      satQ <= 1'b0;
      recQ <= 1'b0;
    end else if (strobes.load) begin
      opA  <= srcA;
      opB  <= srcB;
      srcQ <= elemWidth_t'(srcWidth);
      dstQ <= elemWidth_t'(dstWidth);
      sgnQ <= isSigned;
      subQ <= opSub;
      satQ <= satEn;
      recQ <= recEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstVec  <= '0;
      ovFlags <= '0;
    end else if (strobes.load) begin
      ovFlags <= '0;
    end else if (strobes.wrEn) begin
      ovFlags[elemIdx] <= recQ & clampHit;
      case (dstQ)
        EW8:  dstVec[elemIdx*8 +: 8]   <= resElem[7:0];
        EW16: dstVec[elemIdx*16 +: 16] <= resElem[15:0];
        EW32: dstVec[elemIdx*32 +: 32] <= resElem[31:0];
        default: dstVec[elemIdx*64 +: 64] <= resElem;
      endcase
    end
  end

endmodule

// File: rtl/vecSatAlu.sv
module vecSatAlu
  import vecSatAlu_pkg::*;
#(
  parameter int MAX_VL = 8,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int PACKW = MAX_VL * 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VLW-1:0]    vl,
  input  logic [1:0]        srcWidth,
  input  logic [1:0]        dstWidth,
  input  logic              isSigned,
  input  logic              opSub,
  input  logic              satEn,
  input  logic              recEn,
  input  logic              ovEn,
  input  logic [PACKW-1:0]  srcA,
  input  logic [PACKW-1:0]  srcB,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [PACKW-1:0]  dstVec,
  output logic [MAX_VL-1:0] ovFlags
);

  localparam int IDXW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

  ctrlStrobes_t    strobes;
  logic [IDXW-1:0] elemIdx;

  vecSatAlu_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .vl      (vl),
    .satEn   (satEn),
    .ovEn    (ovEn),
    .strobes (strobes),
    .elemIdx (elemIdx),
    .busy    (busy),
    .done    (done),
    .illegal (illegal)
  );

  vecSatAlu_dp #(.MAX_VL(MAX_VL)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .elemIdx  (elemIdx),
    .srcA     (srcA),
    .srcB     (srcB),
    .srcWidth (srcWidth),
    .dstWidth (dstWidth),
    .isSigned (isSigned),
    .opSub    (opSub),
    .satEn    (satEn),
    .recEn    (recEn),
    .dstVec   (dstVec),
    .ovFlags  (ovFlags)
  );

endmodule

// File: rtl/vecSatAlu_chk.sv
module vecSatAlu_chk #(
  parameter int MAX_VL = 8,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int PACKW = MAX_VL * 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [VLW-1:0]    vl,
  input logic              satEn,
  input logic              ovEn,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic [PACKW-1:0]  dstVec,
  input logic [MAX_VL-1:0] ovFlags
);

  logic           launch;
  logic           satSeen;
  logic [VLW-1:0] vlSeen;
  logic [VLW:0]   busyCnt;

  assign launch = start && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      satSeen <= 1'b0;
      vlSeen  <= '0;
      busyCnt <= '0;
    end else if (launch) begin
      satSeen <= satEn;
      vlSeen  <= (vl > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl;
      busyCnt <= '0;
    end else if (busy) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end

  // R8
  illegal_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    launch && satEn && ovEn |=> illegal && done && !busy);

  // R8
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> $stable(dstVec) && (ovFlags == '0));

  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    launch && (vl == '0) && !(satEn && ovEn) |=> done && !busy);

  // R2
  length_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !illegal |-> busyCnt == {1'b0, vlSeen});

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R3
  no_sat_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !satSeen |-> ovFlags == '0);

endmodule

bind vecSatAlu vecSatAlu_chk #(.MAX_VL(MAX_VL)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .vl      (vl),
  .satEn   (satEn),
  .ovEn    (ovEn),
  .busy    (busy),
  .done    (done),
  .illegal (illegal),
  .dstVec  (dstVec),
  .ovFlags (ovFlags)
);

// File: tb/vecSatAlu_bench.sv
`timescale 1ns/1ps
module vecSatAlu_bench;

  localparam int MAX_VL = 8;
  localparam int VLW = $clog2(MAX_VL + 1);
  localparam int PACKW = MAX_VL * 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN;
  logic              start;
  logic [VLW-1:0]    vl;
  logic [1:0]        srcWidth, dstWidth;
  logic              isSigned, opSub, satEn, recEn, ovEn;
  logic [PACKW-1:0]  srcA, srcB;
  logic              busy, done, illegal;
  logic [PACKW-1:0]  dstVec;
  logic [MAX_VL-1:0] ovFlags;

  vecSatAlu #(.MAX_VL(MAX_VL)) u_vecSatAlu (
    .clk(clk), .rstN(rstN), .start(start), .vl(vl),
    .srcWidth(srcWidth), .dstWidth(dstWidth), .isSigned(isSigned),
    .opSub(opSub), .satEn(satEn), .recEn(recEn), .ovEn(ovEn),
    .srcA(srcA), .srcB(srcB), .busy(busy), .done(done),
    .illegal(illegal), .dstVec(dstVec), .ovFlags(ovFlags)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [PACKW-1:0]  expDst = '0;
  logic [MAX_VL-1:0] expFlags = '0;

  task automatic check(input bit ok, input string req,
                       input logic [PACKW-1:0] act, input logic [PACKW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PACKW-1:0] putElem(input logic [PACKW-1:0] v,
                                               input int i, input int wBits,
                                               input logic [63:0] val);
    logic [PACKW-1:0] r = v;
    for (int k = 0; k < wBits; k++) r[i*wBits + k] = val[k];
    return r;
  endfunction

  function automatic logic [PACKW-1:0] randVec();
    logic [PACKW-1:0] r;
    for (int k = 0; k < PACKW/32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  // Independent element model from the requirements
  task automatic modelElem(input logic [63:0] a, input logic [63:0] b,
                           input int sb, input int db, input bit sgn,
                           input bit sub, input bit sat,
                           output logic [63:0] r, output bit ov);
    logic signed [65:0] ea, eb, full, hi, lo, pick;
    logic [63:0] msk;
    for (int k = 0; k < 66; k++) begin
      ea[k] = (k < sb) ? a[k] : (sgn ? a[sb-1] : 1'b0);
      eb[k] = (k < sb) ? b[k] : (sgn ? b[sb-1] : 1'b0);
    end
    full = sub ? ea - eb : ea + eb;
    if (sgn) begin
      hi = (66'sd1 <<< (db - 1)) - 66'sd1;
      lo = -(66'sd1 <<< (db - 1));
    end else begin
      hi = (66'sd1 <<< db) - 66'sd1;
      lo = 66'sd0;
    end
    ov = 0;
    pick = full;
    if (sat && full > hi) begin pick = hi; ov = 1; end
    else if (sat && full < lo) begin pick = lo; ov = 1; end
    msk = (db == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << db) - 64'd1);
    r = pick[63:0] & msk;
  endtask

  task automatic runOp(input int n, input int sw, input int dw, input bit sgn,
                       input bit sub, input bit satE, input bit recE, input bit ovE,
                       input logic [PACKW-1:0] a, input logic [PACKW-1:0] b,
                       input bit interfere, input string tag);
    int sb = 8 << sw;
    int db = 8 << dw;
    bit ill = satE && ovE;
    int cyc;
    int expCyc;
    logic [63:0] ai, bi, ri;
    bit ov;
    bit sawBusy = 0;
    expFlags = '0;
    if (!ill) begin
      for (int i = 0; i < n; i++) begin
        ai = 64'(a >> (i*sb));
        bi = 64'(b >> (i*sb));
        modelElem(ai, bi, sb, db, sgn, sub, satE, ri, ov);
        expDst = putElem(expDst, i, db, ri);
        expFlags[i] = recE && ov;
      end
    end
    expCyc = (ill || n == 0) ? 1 : n + 1;

    @(negedge clk);
    vl = VLW'(n); srcWidth = 2'(sw); dstWidth = 2'(dw);
    isSigned = sgn; opSub = sub; satEn = satE; recEn = recE; ovEn = ovE;
    srcA = a; srcB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      if (busy) sawBusy = 1;
      if (interfere && cyc == 2) begin
        start = 1'b1; srcA = ~a; opSub = ~sub; vl = VLW'(1); satEn = 1'b0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == expCyc, {tag, " R2 done timing"}, PACKW'(cyc), PACKW'(expCyc));
    check(!busy, {tag, " R2 idle at done"}, PACKW'(busy), '0);
    check(illegal == ill, {tag, " R8 illegal flag"}, PACKW'(illegal), PACKW'(ill));
    check(dstVec == expDst, {tag, " dst"}, dstVec, expDst);
    check(ovFlags == expFlags, {tag, " R6 flags"}, PACKW'(ovFlags), PACKW'(expFlags));
    if (n > 1 && !ill) check(sawBusy, {tag, " R2 busy"}, PACKW'(sawBusy), PACKW'(1));
  endtask

  initial begin
    logic [PACKW-1:0] a, b;
    void'($urandom(32'd20240607));
    rstN = 1'b0; start = 1'b0; vl = '0; srcWidth = '0; dstWidth = '0;
    isSigned = 0; opSub = 0; satEn = 0; recEn = 0; ovEn = 0;
    srcA = '0; srcB = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!busy && !done && !illegal, "R1 control outputs", PACKW'({busy, done, illegal}), '0);
    check(dstVec == '0, "R1 dstVec", dstVec, '0);
    check(ovFlags == '0, "R1 ovFlags", PACKW'(ovFlags), '0);

    // R4 R7: signed 8-bit clamps, per-element flags
    a = '0; b = '0;
    a = putElem(a, 0, 8, 64'd100);  b = putElem(b, 0, 8, 64'd100);
    a = putElem(a, 1, 8, 64'h9C);   b = putElem(b, 1, 8, 64'h9C);
    a = putElem(a, 2, 8, 64'd5);    b = putElem(b, 2, 8, 64'd6);
    runOp(3, 0, 0, 1, 0, 1, 1, 0, a, b, 0, "R4 R7 signed8");
    check(dstVec[23:0] == 24'h0B807F, "R4 clamp values", PACKW'(dstVec[23:0]), PACKW'(24'h0B807F));
    check(ovFlags[2:0] == 3'b011, "R7 per-element flags", PACKW'(ovFlags), PACKW'(3'b011));

    // R5: unsigned 8-bit, negative difference and overflow
    a = '0; b = '0;
    a = putElem(a, 0, 8, 64'd3);   b = putElem(b, 0, 8, 64'd5);
    a = putElem(a, 1, 8, 64'd250); b = putElem(b, 1, 8, 64'd1);
    runOp(2, 0, 0, 0, 1, 1, 1, 0, a, b, 0, "R5 unsigned sub");
    check(dstVec[15:0] == 16'hF900, "R5 clamp to zero", PACKW'(dstVec[15:0]), PACKW'(16'hF900));
    a = putElem('0, 0, 8, 64'd200); b = putElem('0, 0, 8, 64'd100);
    runOp(1, 0, 0, 0, 0, 1, 1, 0, a, b, 0, "R5 unsigned add");
    check(dstVec[7:0] == 8'hFF && ovFlags[0], "R5 clamp to max", PACKW'(dstVec[7:0]), PACKW'(8'hFF));

    // R3: wrap with saturation off, recording on
    runOp(1, 0, 0, 0, 0, 0, 1, 0, a, b, 0, "R3 wrap");
    check(dstVec[7:0] == 8'd44 && ovFlags == '0, "R3 wrap value", PACKW'(dstVec[7:0]), PACKW'(8'd44));

    // R9: wide source, narrow destination; narrow source, wide destination
    a = putElem('0, 0, 64, 64'd1000); b = '0;
    runOp(1, 3, 0, 1, 0, 1, 1, 0, a, b, 0, "R9 64to8");
    check(dstVec[7:0] == 8'h7F, "R9 wide clamp", PACKW'(dstVec[7:0]), PACKW'(8'h7F));
    a = putElem('0, 0, 8, 64'h80); b = putElem('0, 0, 8, 64'h80);
    runOp(1, 0, 1, 1, 0, 1, 1, 0, a, b, 0, "R9 8to16");
    check(dstVec[15:0] == 16'hFF00 && ovFlags == '0, "R9 no clamp when wide", PACKW'(dstVec[15:0]), PACKW'(16'hFF00));

    // R6: recording off hides saturation
    a = putElem('0, 0, 8, 64'd100); b = putElem('0, 0, 8, 64'd100);
    runOp(1, 0, 0, 1, 0, 1, 0, 0, a, b, 0, "R6 rec off");

    // R8: illegal combination
    runOp(4, 1, 1, 1, 0, 1, 1, 1, randVec(), randVec(), 0, "R8 illegal");

    // R10 R12: zero length leaves everything
    runOp(0, 2, 2, 0, 0, 1, 1, 0, randVec(), randVec(), 0, "R10 R12 zero length");

    // R11: start during a run is ignored
    runOp(MAX_VL, 1, 2, 1, 1, 1, 1, 0, randVec(), randVec(), 1, "R11 ignore start");

    // R2 R3 R4 R5 R9 R12: random operations
    for (int t = 0; t < 250; t++) begin
      int n = $urandom_range(0, MAX_VL);
      bit s = $urandom_range(0, 3) != 0;
      bit o = $urandom_range(0, 9) == 0;
      runOp(n, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1),
            $urandom_range(0, 1), s, $urandom_range(0, 3) != 0, o,
            randVec(), randVec(), 0, "R2 R4 R5 R9 R12 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #700000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule